// File: doc/BRIEF.md
# SDRAM Command Sequence Monitor

This block watches the command and address lines of a four-bank single-data-rate SDRAM. It never drives anything. On every rising clock edge it decodes the command that is present. It keeps an idle or open flag and a set of spacing timers for each bank, plus a few timers shared by all banks. When a command breaks the protocol or arrives too soon after an earlier one, the block latches a flag and a four-bit code that says what went wrong.

The minimum spacings for activate-to-column, precharge-to-activate, activate-to-activate and activate-to-precharge are given in clock cycles on configuration inputs. The burst length code tells the monitor how long an auto-precharge burst keeps the column path busy. The first violation stays on the outputs until a synchronous clear arrives. No row addresses are stored, because only the auto-precharge / all-banks address bit is an input.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: After reset, and in the cycle after `clr` is sampled high, `err` is 0 and `err_code` is 0. A violation in the same cycle as `clr` is discarded.
- R2: A command is decoded only when `cs_n` is low and `cke` was high at the previous edge. Encodings on (`ras_n`,`cas_n`,`we_n`) are: 000 mode set, 001 refresh, 011 activate, 010 precharge, 101 read, 100 write, 110 burst stop, 111 no-op. A cycle with `cs_n` high, or one following a low `cke`, has no effect.
- R3: `err` rises one cycle after the first violating command and then holds `err_code` unchanged. When one command breaks several rules, the lowest code is reported.
- R4: A mode set or a refresh issued while any bank is open gives code 1.
- R5: Any command other than no-op issued fewer than `MRD` (default 2) cycles after a mode set gives code 2.
- R6: A read or write to an idle bank gives code 3. An activate to an open bank gives code 4.
- R7: A read or write issued fewer than `t_rcd` cycles after its bank was activated gives code 5.
- R8: An activate issued while its bank's precharge window is still running gives code 6. That window is `t_rp` cycles after a precharge that closed the bank.
- R9: An activate issued fewer than `t_rrd` cycles after any activate gives code 7.
- R10: A precharge that closes an open bank fewer than `t_ras` cycles after that bank's activate gives code 8.
- R11: A precharge with `a10` high closes all four banks. With `a10` low it closes only bank `ba`. A precharge of an idle bank changes nothing.
- R12: A read or write with `a10` high closes its bank at once. Any read or write fewer than BL cycles later gives code 9. An activate to that bank fewer than BL+`t_rp` cycles later gives code 6.
- R13: `bl_code` maps 0→1, 1→2, 2→4, 3→8 and 7→`PAGE_LEN`; other values count as 1. Column commands one cycle apart without auto precharge are legal, and burst stop is legal in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; all inputs sampled on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of the latched error |
| cke | input | 1 | Clock enable line of the memory bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks bit |
| bl_code | input | 3 | Programmed burst length code |
| t_rcd | input | TW | Activate-to-column spacing, cycles |
| t_rp | input | TW | Precharge-to-activate spacing, cycles |
| t_rrd | input | TW | Activate-to-activate spacing, cycles |
| t_ras | input | TW | Activate-to-precharge spacing, cycles |
| err | output | 1 | Sticky violation flag |
| err_code | output | 4 | Code of the first violation |

## Verification
A wrong bank flag shows up as a false code 3 or code 4 on the next column command or activate to that bank. A timer that reloads wrong or counts one cycle off moves the boundary between a clean command and a code 5–9 by one cycle. For that reason each spacing is probed at the last illegal cycle and at the first legal one. Every such fault appears on `err` one cycle after the command that exposes it. The sticky latch and the priority order are checked by issuing commands that break two rules at once and by issuing further violations after the first one.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int TW       = 6,
  parameter int PAGE_LEN = 512,
  parameter int MRD      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cke,
  input  logic          cs_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic [1:0]    ba,
  input  logic          a10,
  input  logic [2:0]    bl_code,
  input  logic [TW-1:0] t_rcd,
  input  logic [TW-1:0] t_rp,
  input  logic [TW-1:0] t_rrd,
  input  logic [TW-1:0] t_ras,
  output logic          err,
  output logic [3:0]    err_code
);
  localparam int CW = $clog2(PAGE_LEN + (1 << TW) + 1) + 1;

  function automatic logic [TW-1:0] ld_t(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - TW'(1);
  endfunction
  function automatic logic [CW-1:0] ld_c(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - CW'(1);
  endfunction

  logic          cke_q;
  logic [3:0]    open_q;
  logic [TW-1:0] rcd_t [4];
  logic [TW-1:0] ras_t [4];
  logic [CW-1:0] rp_t  [4];
  logic [TW-1:0] rrd_t, mrd_t;
  logic [CW-1:0] apl_t, bl_len;
  logic [3:0]    ras_busy, viol;

  wire live  = !cs_n && cke_q;
  wire c_mrs = live && !ras_n && !cas_n && !we_n;
  wire c_ref = live && !ras_n && !cas_n &&  we_n;
  wire c_act = live && !ras_n &&  cas_n &&  we_n;
  wire c_pre = live && !ras_n &&  cas_n && !we_n;
  wire c_col = live &&  ras_n && !cas_n;
  wire c_any = live && !(ras_n && cas_n && we_n);
  wire c_ap  = c_col && a10;

  always_comb begin
    case (bl_code)
      3'd1:    bl_len = CW'(2);
      3'd2:    bl_len = CW'(4);
      3'd3:    bl_len = CW'(8);
      3'd7:    bl_len = CW'(PAGE_LEN);
      default: bl_len = CW'(1);
    endcase
  end

  always_comb
    for (int i = 0; i < 4; i++) ras_busy[i] = open_q[i] && (ras_t[i] != '0);

  always_comb begin
    if ((c_mrs || c_ref) && (open_q != '0))            viol = 4'd1;
    else if (c_any && mrd_t != '0)                      viol = 4'd2;
    else if (c_col && !open_q[ba])                      viol = 4'd3;
    else if (c_act && open_q[ba])                       viol = 4'd4;
    else if (c_col && rcd_t[ba] != '0)                  viol = 4'd5;
    else if (c_act && rp_t[ba] != '0)                   viol = 4'd6;
    else if (c_act && rrd_t != '0)                      viol = 4'd7;
    else if (c_pre && (a10 ? (ras_busy != '0) : ras_busy[ba])) viol = 4'd8;
    else if (c_col && apl_t != '0)                      viol = 4'd9;
    else                                                viol = 4'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q  <= 1'b1;
      open_q <= '0;
      rrd_t  <= '0;
      mrd_t  <= '0;
      apl_t  <= '0;
      for (int i = 0; i < 4; i++) begin
        rcd_t[i] <= '0;
        ras_t[i] <= '0;
        rp_t[i]  <= '0;
      end
    end else begin
      cke_q <= cke;
      rrd_t <= c_act ? ld_t(t_rrd) : rrd_t - TW'(rrd_t != '0);
      mrd_t <= c_mrs ? TW'(MRD - 1) : mrd_t - TW'(mrd_t != '0);
      apl_t <= c_ap ? ld_c(bl_len) : apl_t - CW'(apl_t != '0);
      for (int i = 0; i < 4; i++) begin
        if (c_act && ba == 2'(i)) begin
          open_q[i] <= 1'b1;
          rcd_t[i]  <= ld_t(t_rcd);
          ras_t[i]  <= ld_t(t_ras);
        end else begin
          rcd_t[i] <= rcd_t[i] - TW'(rcd_t[i] != '0);
          ras_t[i] <= ras_t[i] - TW'(ras_t[i] != '0);
        end
        if (c_pre && (a10 || ba == 2'(i)) && open_q[i]) begin
          open_q[i] <= 1'b0;
          rp_t[i]   <= CW'(ld_t(t_rp));
        end else if (c_ap && ba == 2'(i)) begin
          open_q[i] <= 1'b0;
          rp_t[i]   <= ld_c(bl_len + CW'(t_rp));
        end else begin
          rp_t[i] <= rp_t[i] - CW'(rp_t[i] != '0);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      err      <= 1'b0;
      err_code <= '0;
    end else if (!err && viol != '0) begin
      err      <= 1'b1;
      err_code <= viol;
    end
  end

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!err && err_code == '0));
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr) |=> (err && $stable(err_code)));
  p_flag_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err == (err_code != '0));
  p_act_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
    c_act |=> open_q[$past(ba)]);
  p_preall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (c_pre && a10) |=> (open_q == '0));
  p_ap_closes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    c_ap |=> !open_q[$past(ba)]);
endmodule

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb;
  localparam logic [2:0] MRS = 3'b000, REF = 3'b001, ACT = 3'b011, PRE = 3'b010,
                         RD = 3'b101, WR = 3'b100, BST = 3'b110;
  logic clk = 0, rst_n = 0, clr = 0, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, a10 = 0;
  logic [1:0] ba = 0;
  logic [2:0] bl_code = 3'd2;
  logic [5:0] t_rcd = 3, t_rp = 3, t_rrd = 2, t_ras = 5;
  logic err;
  logic [3:0] err_code;
  int checks = 0, fails = 0;

  sdram_cmd_monitor u_dut (.clk(clk), .rst_n(rst_n), .clr(clr), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .bl_code(bl_code),
    .t_rcd(t_rcd), .t_rp(t_rp), .t_rrd(t_rrd), .t_ras(t_ras), .err(err), .err_code(err_code));

  always #10 clk = ~clk;

  task automatic chk(input logic e, input logic [3:0] c, input string tag);
    checks++;
    if (err !== e || err_code !== c) begin
      fails++;
      $display("FAIL %s: got err=%0b code=%0d, expected err=%0b code=%0d", tag, err, err_code, e, c);
    end
  endtask

  task automatic nop(input int n);
    cs_n = 0; {ras_n, cas_n, we_n} = 3'b111;
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] c, input logic [1:0] b, input logic a);
    cs_n = 0; {ras_n, cas_n, we_n} = c; ba = b; a10 = a;
    @(negedge clk);
    {ras_n, cas_n, we_n} = 3'b111; a10 = 0;
  endtask

  task automatic reset();
    rst_n = 0; clr = 0; cke = 1; cs_n = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    nop(1);
  endtask

  task automatic clear();
    clr = 1; nop(1); clr = 0;
  endtask

  task automatic t_reset();
    reset(); chk(0, 0, "R1 reset state");
  endtask

  task automatic t_legal();
    reset();
    cmd(ACT, 0, 0); nop(2); cmd(RD, 0, 0); cmd(RD, 0, 0);
    chk(0, 0, "R13 back-to-back reads at tCCD 1");
    cmd(BST, 0, 0); chk(0, 0, "R13 burst stop legal");
    cmd(PRE, 0, 0); nop(2); cmd(ACT, 0, 0);
    chk(0, 0, "R7 R8 R10 legal sequence at exact spacings");
  endtask

  task automatic t_rcd_chk();
    reset(); cmd(ACT, 1, 0); nop(1); cmd(RD, 1, 0); chk(1, 5, "R7 read at tRCD-1");
  endtask

  task automatic t_idle_open();
    reset(); cmd(WR, 2, 0); chk(1, 3, "R6 write to idle bank");
    reset(); cmd(ACT, 0, 0); nop(3); cmd(ACT, 0, 0); chk(1, 4, "R6 activate open bank");
    reset(); cmd(ACT, 0, 0); cmd(ACT, 0, 0); chk(1, 4, "R3 priority code 4 over 7");
    cmd(WR, 3, 0); chk(1, 4, "R3 first error held");
  endtask

  task automatic t_rrd_chk();
    reset(); cmd(ACT, 0, 0); cmd(ACT, 1, 0); chk(1, 7, "R9 activate at tRRD-1");
    clear(); chk(0, 0, "R1 clear");
    cmd(ACT, 2, 0); clr = 1; cmd(ACT, 3, 0); clr = 0;
    chk(0, 0, "R1 clear wins over violation");
  endtask

  task automatic t_ras_rp();
    reset(); cmd(ACT, 0, 0); nop(2); cmd(PRE, 0, 0); chk(1, 8, "R10 precharge at tRAS-2");
    reset(); cmd(ACT, 0, 0); nop(4); cmd(PRE, 0, 0); nop(1); cmd(ACT, 0, 0);
    chk(1, 6, "R8 activate at tRP-1");
  endtask

  task automatic t_mode();
    reset(); cmd(ACT, 0, 0); nop(2); cmd(MRS, 0, 0); chk(1, 1, "R4 mode set with open bank");
    reset(); cmd(ACT, 0, 0); nop(2); cmd(REF, 0, 0); chk(1, 1, "R4 refresh with open bank");
    reset(); cmd(MRS, 0, 0); cmd(ACT, 0, 0); chk(1, 2, "R5 command one cycle after mode set");
    reset(); cmd(MRS, 0, 0); nop(1); cmd(ACT, 0, 0); chk(0, 0, "R5 command two cycles after mode set");
  endtask

  task automatic t_decode();
    reset(); cmd(ACT, 0, 0); nop(3);
    cs_n = 1; {ras_n, cas_n, we_n} = MRS; @(negedge clk);
    {ras_n, cas_n, we_n} = 3'b111; nop(1);
    chk(0, 0, "R2 deselect ignored");
    cke = 0; nop(1); cmd(MRS, 0, 0); cke = 1; nop(1);
    chk(0, 0, "R2 command after low cke ignored");
    cmd(ACT, 0, 0); chk(1, 4, "R2 bank state kept through ignored cycles");
  endtask

  task automatic t_prech();
    reset(); cmd(ACT, 0, 0); nop(1); cmd(ACT, 2, 0); nop(4); cmd(PRE, 0, 1); nop(2);
    cmd(RD, 0, 0); chk(1, 3, "R11 precharge all closes bank 0");
    reset(); cmd(ACT, 0, 0); nop(1); cmd(ACT, 2, 0); nop(4); cmd(PRE, 0, 1); nop(2);
    cmd(ACT, 2, 0); chk(0, 0, "R11 precharge all closes bank 2");
    reset(); cmd(ACT, 0, 0); nop(1); cmd(ACT, 1, 0); nop(4); cmd(PRE, 1, 0);
    cmd(RD, 0, 0); chk(0, 0, "R11 single precharge leaves bank 0 open");
    cmd(PRE, 3, 0); cmd(ACT, 3, 0); chk(0, 0, "R11 precharge of idle bank no effect");
  endtask

  task automatic ap_setup();
    reset(); cmd(ACT, 1, 0); nop(1); cmd(ACT, 0, 0); nop(2); cmd(RD, 0, 1);
  endtask

  task automatic t_ap();
    ap_setup(); cmd(RD, 1, 0); chk(1, 9, "R12 column inside auto precharge burst");
    ap_setup(); nop(3); cmd(RD, 1, 0); chk(0, 0, "R12 column at burst end");
    ap_setup(); nop(5); cmd(ACT, 0, 0); chk(1, 6, "R12 activate at BL+tRP-1");
    ap_setup(); nop(6); cmd(ACT, 0, 0); chk(0, 0, "R12 activate at BL+tRP");
    ap_setup(); nop(6); cmd(WR, 0, 0); chk(1, 3, "R12 bank closed by auto precharge");
    bl_code = 3'd7;
    ap_setup(); nop(3); cmd(RD, 1, 0); chk(1, 9, "R13 full page burst still busy");
    bl_code = 3'd0;
    ap_setup(); cmd(RD, 1, 0); chk(0, 0, "R13 burst of one frees column path");
    bl_code = 3'd2;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset(); t_legal(); t_rcd_chk(); t_idle_open(); t_rrd_chk();
    t_ras_rp(); t_mode(); t_decode(); t_prech(); t_ap();
    summary();
    $finish;
  end
endmodule